// File: doc/BRIEF.md
# Quad Wiper Register Serial Slave

This block is a two-wire serial slave that keeps four 8-bit wiper codes for a quad digital potentiometer. It watches the clock and data lines of an I2C-style bus through a synchronizer and a small glitch filter. It recognises START and STOP, and it accepts a write frame of three bytes: an identification byte, a register address byte and a data byte. It acknowledges each byte and then waits in standby for the next START.

The identification byte carries a fixed 5-bit device code, two strap bits and a read/write flag. The strap bits let several of these slaves share one bus. A read first sets the register pointer with an identification byte and an address byte. The master then issues a repeated START and an identification byte with the read flag set. The selected code is shifted out MSB first until the master answers with NACK. The four codes go out in parallel to the resistor array.

Top module: `wiper_serial_slave`

## Requirements
- R1: After reset every wiper code is 80h and the slave does not pull SDA low.
- R2: START, an identification byte (bits 7..3 = 10100, bits 2..1 = strap_i[1:0], bit 0 = 0), an address byte of 0 to 3 and a data byte load the data into that wiper. Each of the three bytes gets an ACK, which means SDA is held low during the ninth SCL pulse.
- R3: An identification byte whose device code or strap bits do not match gets no ACK. Every later byte up to the next START is also ignored, with no ACK and no wiper change.
- R4: An address byte of 4 or more gets no ACK, and no wiper changes in that frame.
- R5: A wiper changes only when its data byte has been acknowledged. A STOP or a repeated START before that point leaves every wiper as it was.
- R6: After an acknowledged address byte, a repeated START with identification bit 0 = 1 gets an ACK. The selected wiper is then sent MSB first. A master ACK makes the same code repeat. A master NACK ends the read, and after it the slave leaves SDA released.
- R7: A read identification byte with no pointer set since the last STOP gets no ACK.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles is ignored. It neither counts as a bit nor forms a START or a STOP.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After the data byte of a write frame, further bytes get no ACK and do not change any wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Board strap bits compared with identification bits 2..1 |
| sda_pull_o | output | 1 | 1 = pull the open-drain SDA line low |
| wiper_o | output | 32 | Four wiper codes, wiper 0 in bits 7..0 |

## Verification
A stuck or wrong sequencer state shows at the ports within one byte time. An ACK is missing or appears where none belongs, or SDA stays pulled low when it should be released. A wrong pointer or a commit at the wrong time shows on wiper_o right after the frame, and the bad value also comes back in a read. A filter that lets glitches through turns a single short pulse into an extra bit or a false START. That breaks the acknowledge pattern of the same frame.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_SKIP
  } phase_e;

  // identification byte: code in [7:3], strap in [2:1], direction in [0]
  function automatic logic id_matches(input logic [7:0] b,
                                      input logic [4:0] code,
                                      input logic [1:0] strap);
    return (b[7:3] == code) && (b[2:1] == strap);
  endfunction

  function automatic logic addr_in_range(input logic [7:0] b,
                                         input int unsigned count);
    return {24'd0, b} < count;
  endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        clean <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FILTER_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> (clean == $past(s2))); // R8

endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl && !scl_q;
  assign scl_fall  = !scl && scl_q;
  assign start_evt = scl && scl_q && sda_q && !sda;
  assign stop_evt  = scl && scl_q && !sda_q && sda;

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int          NUM        = 4,
  parameter int          W          = 8,
  parameter logic [7:0]  RESET_CODE = 8'h80,
  localparam int         IW         = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [W-1:0]      wdata,
  output logic [NUM*W-1:0]  codes
);
  logic [W-1:0] regs [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= W'(RESET_CODE);
      end else if (we && (idx == IW'(g))) begin
        regs[g] <= wdata;
      end
    end
    assign codes[g*W +: W] = regs[g];
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(codes)); // R5

endmodule

// File: rtl/wiper_serial_slave.sv
module wiper_serial_slave
  import wiper_pkg::*;
#(
  parameter int         NUM_WIPERS = 4,
  parameter logic [4:0] DEV_CODE   = 5'b10100,
  parameter int         FILT_LEN   = 4,
  parameter logic [7:0] RESET_CODE = 8'h80,
  localparam int        BYTE_W     = 8,
  localparam int        IW         = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic [1:0]                   strap_i,
  output logic                         sda_pull_o,
  output logic [NUM_WIPERS*BYTE_W-1:0] wiper_o
);

  function automatic logic [BYTE_W-1:0] pick(input logic [NUM_WIPERS*BYTE_W-1:0] v,
                                             input logic [IW-1:0] i);
    return v[i*BYTE_W +: BYTE_W];
  endfunction

  // ---- line conditioning ----
  logic [1:0] raw_lines, clean_lines;
  logic       scl_f, sda_f;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end
  assign scl_f = clean_lines[1];
  assign sda_f = clean_lines[0];

  logic scl_rise, scl_fall, start_evt, stop_evt;
  bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_f),
    .sda       (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  // ---- protocol sequencer ----
  phase_e            phase;
  logic [3:0]        bitn;
  logic              in_ack;
  logic [BYTE_W-1:0] shreg;
  logic [IW-1:0]     ptr;
  logic              ptr_ok;
  logic              master_nak;
  logic              sda_pull;

  logic rx_phase, byte_done, accept, wr_commit;
  logic [BYTE_W-1:0] sel_code;

  assign sel_code  = pick(wiper_o, ptr);
  assign rx_phase  = (phase == PH_ID) || (phase == PH_ADDR) || (phase == PH_DATA);
  assign byte_done = rx_phase && scl_fall && !in_ack && (bitn == 4'd8);
  assign wr_commit = (phase == PH_DATA) && scl_fall && in_ack && sda_pull;

  always_comb begin
    unique case (phase)
      PH_ID:   accept = id_matches(shreg, DEV_CODE, strap_i) && (!shreg[0] || ptr_ok);
      PH_ADDR: accept = addr_in_range(shreg, NUM_WIPERS);
      PH_DATA: accept = 1'b1;
      default: accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bitn       <= '0;
      in_ack     <= 1'b0;
      shreg      <= '0;
      ptr        <= '0;
      ptr_ok     <= 1'b0;
      master_nak <= 1'b0;
      sda_pull   <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      bitn     <= '0;
      in_ack   <= 1'b0;
      ptr_ok   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      phase    <= PH_ID;
      bitn     <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (scl_rise) begin
      if (rx_phase && !in_ack && (bitn < 4'd8)) begin
        shreg <= {shreg[BYTE_W-2:0], sda_f};
        bitn  <= bitn + 4'd1;
      end else if ((phase == PH_READ) && (bitn == 4'd8)) begin
        master_nak <= sda_f;
      end
    end else if (scl_fall) begin
      if (byte_done) begin
        in_ack   <= 1'b1;
        sda_pull <= accept;
      end else if (rx_phase && in_ack) begin
        in_ack   <= 1'b0;
        bitn     <= '0;
        sda_pull <= 1'b0;
        if (!sda_pull) begin
          phase <= PH_SKIP;
        end else begin
          unique case (phase)
            PH_ID: begin
              if (shreg[0]) begin
                phase    <= PH_READ;
                shreg    <= sel_code;
                sda_pull <= ~sel_code[BYTE_W-1];
              end else begin
                phase  <= PH_ADDR;
                ptr_ok <= 1'b0;
              end
            end
            PH_ADDR: begin
              phase  <= PH_DATA;
              ptr    <= shreg[IW-1:0];
              ptr_ok <= 1'b1;
            end
            default: phase <= PH_SKIP;
          endcase
        end
      end else if (phase == PH_READ) begin
        if (bitn < 4'd7) begin
          shreg    <= {shreg[BYTE_W-2:0], 1'b0};
          sda_pull <= ~shreg[BYTE_W-2];
          bitn     <= bitn + 4'd1;
        end else if (bitn == 4'd7) begin
          sda_pull <= 1'b0;
          bitn     <= 4'd8;
        end else if (master_nak) begin
          phase    <= PH_SKIP;
          sda_pull <= 1'b0;
        end else begin
          shreg    <= sel_code;
          sda_pull <= ~sel_code[BYTE_W-1];
          bitn     <= '0;
        end
      end
    end
  end

  assign sda_pull_o = sda_pull;

  // ---- register storage ----
  wiper_bank #(.NUM(NUM_WIPERS), .W(BYTE_W), .RESET_CODE(RESET_CODE)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_commit),
    .idx   (ptr),
    .wdata (shreg),
    .codes (wiper_o)
  );

  // ---- assertions ----
  AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) || (phase == PH_SKIP)) |-> !sda_pull); // R1

  AST_DATA_ALWAYS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_DATA)) |=> sda_pull); // R2

  AST_COMMIT_NEEDS_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ptr_ok); // R5

  AST_ID_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_ID) && !id_matches(shreg, DEV_CODE, strap_i)) |=> !sda_pull); // R3

  AST_ADDR_RANGE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_ADDR) && !addr_in_range(shreg, NUM_WIPERS)) |=> !sda_pull); // R4

  AST_READ_NEEDS_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase == PH_ID) && shreg[0] && !ptr_ok) |=> !sda_pull); // R7

  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!scl_f || $past(stop_evt) || $past(start_evt))); // R9

endmodule

// File: tb/sim_wiper_serial_slave.sv
`timescale 1ns/1ps
module sim_wiper_serial_slave;
  localparam int Q = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        pull;
  logic [31:0] wiper_o;
  logic        sda_line;

  assign sda_line = sda_m & ~pull;

  always #4 clk = ~clk;

  wiper_serial_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_pull_o (pull),
    .wiper_o    (wiper_o)
  );

  int tests = 0;
  int fails = 0;
  int drive_viol = 0;
  logic [7:0]  model [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] model_vec();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic expect_wipers(input string tag);
    waitc(4);
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    waitc(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(wiper_o == e, t, wiper_o, e);
    end
  end

  // R9: SDA drive must not move while SCL is high
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (pull != prev_pull) && scl_m) drive_viol++;
    prev_pull <= pull;
  end

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(2*Q);
    sda_m = 1'b0; waitc(2*Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(2*Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; waitc(4);
    if (glitch) begin
      scl_m = 1'b1; waitc(2); scl_m = 1'b0; waitc(Q-6);
    end else begin
      waitc(Q-4);
    end
    scl_m = 1'b1; waitc(Q/2);
    if (glitch && b) begin
      sda_m = 1'b0; waitc(2); sda_m = 1'b1;
    end
    waitc(Q/2);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q/2);
    b = sda_line;
    waitc(Q/2);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit gl, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], gl && (i == 7));
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!master_ack, 1'b0);
  endtask

  task automatic write_frame(input logic [7:0] id, input logic [7:0] ad, input logic [7:0] dt,
                             input bit gl, output bit a0, output bit a1, output bit a2);
    bus_start();
    send_byte(id, gl, a0);
    send_byte(ad, 1'b0, a1);
    send_byte(dt, 1'b0, a2);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit a0, a1, a2, ax;
    logic [7:0] rd;
    for (int i = 0; i < 4; i++) model[i] = 8'h80;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);

    // R1: reset state
    chk(wiper_o == 32'h80808080, "R1 reset codes", wiper_o, 32'h80808080);
    chk(pull == 1'b0, "R1 SDA released", {31'd0, pull}, 0);

    // R2: plain writes
    write_frame(8'hA4, 8'h02, 8'h3C, 1'b0, a0, a1, a2);
    chk(a0 && a1 && a2, "R2 three ACKs", {29'd0, a0, a1, a2}, 3'b111);
    model[2] = 8'h3C; expect_wipers("R2 write wiper2");
    write_frame(8'hA4, 8'h00, 8'hFF, 1'b0, a0, a1, a2);
    write_frame(8'hA4, 8'h03, 8'h00, 1'b0, a0, a1, a2);
    chk(a0 && a1 && a2, "R2 ACKs wiper3", {29'd0, a0, a1, a2}, 3'b111);
    model[0] = 8'hFF; model[3] = 8'h00; expect_wipers("R2 extreme codes");

    // R3: identification mismatch
    write_frame(8'hAC, 8'h01, 8'h11, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R3 bad code no ACK", {29'd0, a0, a1, a2}, 0);
    write_frame(8'hA2, 8'h01, 8'h22, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R3 bad strap no ACK", {29'd0, a0, a1, a2}, 0);
    expect_wipers("R3 wipers unchanged");

    // R4: address out of range
    write_frame(8'hA4, 8'h04, 8'h55, 1'b0, a0, a1, a2);
    chk(a0 && !a1 && !a2, "R4 addr 4 NACK", {29'd0, a0, a1, a2}, 3'b100);
    write_frame(8'hA4, 8'hFF, 8'h55, 1'b0, a0, a1, a2);
    chk(a0 && !a1 && !a2, "R4 addr FF NACK", {29'd0, a0, a1, a2}, 3'b100);
    expect_wipers("R4 wipers unchanged");

    // R5: aborted frames
    bus_start();
    send_byte(8'hA4, 1'b0, a0);
    send_byte(8'h01, 1'b0, a1);
    bus_stop();
    expect_wipers("R5 stop before data");
    bus_start();
    send_byte(8'hA4, 1'b0, a0);
    send_byte(8'h01, 1'b0, a1);
    for (int i = 7; i >= 4; i--) send_bit(i[0], 1'b0);
    bus_start();
    send_byte(8'hA4, 1'b0, a0);
    send_byte(8'h03, 1'b0, a1);
    send_byte(8'h77, 1'b0, a2);
    bus_stop();
    chk(a0 && a1 && a2, "R5 frame after restart ACKs", {29'd0, a0, a1, a2}, 3'b111);
    model[3] = 8'h77; expect_wipers("R5 partial data dropped");

    // R6: readback
    bus_start();
    send_byte(8'hA4, 1'b0, a0);
    send_byte(8'h02, 1'b0, a1);
    bus_start();
    send_byte(8'hA5, 1'b0, a2);
    chk(a0 && a1 && a2, "R6 read setup ACKs", {29'd0, a0, a1, a2}, 3'b111);
    recv_byte(1'b1, rd);
    chk(rd == 8'h3C, "R6 read first byte", {24'd0, rd}, 32'h3C);
    recv_byte(1'b0, rd);
    chk(rd == 8'h3C, "R6 read repeated byte", {24'd0, rd}, 32'h3C);
    recv_byte(1'b0, rd);
    chk(rd == 8'hFF, "R6 released after NACK", {24'd0, rd}, 32'hFF);
    bus_stop();

    // R7: read without pointer
    bus_start();
    send_byte(8'hA5, 1'b0, ax);
    bus_stop();
    chk(!ax, "R7 read w/o pointer NACK", {31'd0, ax}, 0);

    // R8: glitches on both lines during the identification byte
    write_frame(8'hA4, 8'h01, 8'h9D, 1'b1, a0, a1, a2);
    chk(a0 && a1 && a2, "R8 glitch frame ACKs", {29'd0, a0, a1, a2}, 3'b111);
    model[1] = 8'h9D; expect_wipers("R8 glitch write");

    // R10: extra bytes after data
    bus_start();
    send_byte(8'hA4, 1'b0, a0);
    send_byte(8'h00, 1'b0, a1);
    send_byte(8'h12, 1'b0, a2);
    send_byte(8'h34, 1'b0, ax);
    bus_stop();
    chk(a2 && !ax, "R10 extra byte NACK", {30'd0, a2, ax}, 2'b10);
    model[0] = 8'h12; expect_wipers("R10 only first data kept");

    // R9
    chk(drive_viol == 0, "R9 drive changes with SCL low", drive_viol, 0);

    waitc(10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule